// File: doc/BRIEF.md
# Tone Channel Frequency Sweep Unit

This block is the frequency sweep stage of a square-wave tone channel in a small handheld sound subsystem. It owns the channel's 11-bit frequency, which software loads as a low byte and a 3-bit high part. On selected steps of a 512 Hz frame sequencer it can move that frequency up or down by a shifted copy of itself. The step size, the direction and the number of eligible steps between updates all come from a control byte.

The block also stores the five channel configuration bytes so that software reads back exactly what it wrote. The live frequency appears on `freq_o` for the waveform generator. `chan_off_o` tells the channel to go silent when an upward sweep would leave the 11-bit range.

Register writes and the sequencer step are single-cycle strobes. Neither has a ready signal, because the block accepts every strobe in the cycle it arrives and never applies back-pressure. Reads are combinational on `rd_addr`.

Top module: `swp_sweep_unit`

## Requirements
- R1: After reset, `freq_o` is 0, `chan_off_o` is 0, and every register offset reads 0.
- R2: Offsets 0 to 4 read back the last byte written to them. Offsets 5 to 7 always read 0, and writes to them change no output.
- R3: A write to offset 3 loads frequency bits 7..0. A write to offset 4 loads frequency bits 10..8 from data bits 2..0. Sweep updates change `freq_o` but not the bytes read back at offsets 3 and 4.
- R4: The control byte at offset 0 holds the period in bits 6..4, the direction in bit 3 (1 = decrease) and the shift n in bits 2..0. Writing it clears the sweep step counter.
- R5: Only a `seq_tick` with `seq_step` equal to 2 or 6 counts as a sweep step. Ticks at any other step leave all outputs unchanged.
- R6: When the period or the shift is 0, a sweep step changes nothing and the counter holds.
- R7: Each sweep step increments the counter. When the count reaches the period, the counter clears and the frequency is updated in the same clock.
- R8: With the direction bit at 0, an update sets the frequency to f + (f >> n).
- R9: With the direction bit at 1, an update sets the frequency to f - (f >> n), which never falls below 0.
- R10: If an increase would give a value above 2047, the frequency stays unchanged and `chan_off_o` goes to 1. It stays at 1 until a write to offset 4.
- R11: A sweep step that arrives in the same cycle as any register write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Byte stored at `rd_addr` |
| seq_tick | input | 1 | Frame-sequencer step strobe |
| seq_step | input | 3 | Current frame-sequencer step (0 to 7) |
| freq_o | output | 11 | Live channel frequency |
| chan_off_o | output | 1 | Channel disable after sweep overflow |

## Verification
The bench builds the block with its default parameters: an 11-bit frequency, eight-bit registers, and eligible steps 2 and 6. At these values the overflow boundary at 2047 can be reached in two updates from 1024. A shift of 1 or 2 makes the decrease and the period counting visible within a few steps.

A random phase mixes writes to all eight offsets, including the unused ones, with ticks on every sequencer step. This reaches the same-cycle write and tick collision and the period-zero and shift-zero cases many times over.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int PER_W = 3;
  localparam int SHF_W = 3;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic             dec;
    logic [SHF_W-1:0] shift;
  } swp_ctl_t;

  // Control byte: period in 6..4, direction in 3, shift in 2..0
  function automatic swp_ctl_t swp_decode(input logic [7:0] b);
    swp_ctl_t c;
    c.period = b[6:4];
    c.dec    = b[3];
    c.shift  = b[2:0];
    return c;
  endfunction
endpackage

// File: rtl/swp_regfile.sv
module swp_regfile #(
  parameter int NREGS  = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NREGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] store [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store[g] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        store[g] <= wr_data;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = store[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = store[i];
  end
endmodule

// File: rtl/swp_pacer.sv
module swp_pacer #(
  parameter int STEP_W = 3,
  parameter int PER_W  = 3,
  parameter int SHF_W  = 3,
  parameter int STEP_A = 2,
  parameter int STEP_B = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic              hold,
  input  logic              clr,
  input  logic [PER_W-1:0]  period,
  input  logic [SHF_W-1:0]  shift,
  output logic              fire,
  output logic [PER_W-1:0]  cnt
);
  logic             on_step;
  logic             live;
  logic [PER_W:0]   cnt_inc;
  logic             reach;

  assign on_step = (step == STEP_W'(STEP_A)) || (step == STEP_W'(STEP_B));
  assign live    = tick && on_step && !hold && (period != '0) && (shift != '0);
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reach   = cnt_inc >= {1'b0, period};
  assign fire    = live && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (live)
      cnt <= reach ? '0 : cnt_inc[PER_W-1:0];
  end
endmodule

// File: rtl/swp_adjust.sv
module swp_adjust #(
  parameter int FREQ_W = 11,
  parameter int SHF_W  = 3
) (
  input  logic [FREQ_W-1:0] freq,
  input  logic [SHF_W-1:0]  shift,
  input  logic              dec,
  output logic [FREQ_W-1:0] freq_next,
  output logic              ovf
);
  logic [FREQ_W-1:0] delta;
  logic [FREQ_W:0]   sum;

  assign delta = freq >> shift;
  assign sum   = {1'b0, freq} + {1'b0, delta};

  always_comb begin
    ovf = 1'b0;
    if (dec) begin
      freq_next = (freq >= delta) ? (freq - delta) : '0;
    end else begin
      freq_next = sum[FREQ_W-1:0];
      ovf       = sum[FREQ_W];
    end
  end
endmodule

// File: rtl/swp_sweep_unit.sv
module swp_sweep_unit #(
  parameter int FREQ_W = 11,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NREGS  = 5,
  parameter int STEP_W = 3,
  parameter int STEP_A = 2,
  parameter int STEP_B = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              seq_tick,
  input  logic [STEP_W-1:0] seq_step,
  output logic [FREQ_W-1:0] freq_o,
  output logic              chan_off_o
);
  import swp_pkg::*;

  localparam int HI_W    = FREQ_W - DATA_W;
  localparam int CTL_OFS = 0;
  localparam int FLO_OFS = 3;
  localparam int FHI_OFS = 4;

  logic [NREGS*DATA_W-1:0] regs_flat;
  swp_ctl_t                ctl;
  logic [PER_W-1:0]        ctl_period;
  logic                    ctl_dec;
  logic [PER_W-1:0]        sweep_cnt;
  logic                    fire;
  logic [FREQ_W-1:0]       freq_q;
  logic [FREQ_W-1:0]       freq_next;
  logic                    ovf;
  logic                    off_q;
  logic                    wr_ctl, wr_lo, wr_hi;

  assign wr_ctl = wr_en && (wr_addr == ADDR_W'(CTL_OFS));
  assign wr_lo  = wr_en && (wr_addr == ADDR_W'(FLO_OFS));
  assign wr_hi  = wr_en && (wr_addr == ADDR_W'(FHI_OFS));

  swp_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );

  assign ctl        = swp_decode(regs_flat[CTL_OFS*DATA_W +: 8]);
  assign ctl_period = ctl.period;
  assign ctl_dec    = ctl.dec;

  swp_pacer #(.STEP_W(STEP_W), .PER_W(PER_W), .SHF_W(SHF_W),
              .STEP_A(STEP_A), .STEP_B(STEP_B)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tick(seq_tick), .step(seq_step),
    .hold(wr_en), .clr(wr_ctl), .period(ctl.period), .shift(ctl.shift),
    .fire(fire), .cnt(sweep_cnt)
  );

  swp_adjust #(.FREQ_W(FREQ_W), .SHF_W(SHF_W)) u_adjust (
    .freq(freq_q), .shift(ctl.shift), .dec(ctl.dec),
    .freq_next(freq_next), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      off_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_lo) freq_q[DATA_W-1:0] <= wr_data;
      if (wr_hi) begin
        freq_q[FREQ_W-1:DATA_W] <= wr_data[HI_W-1:0];
        off_q <= 1'b0;
      end
    end else if (fire) begin
      if (ovf) off_q  <= 1'b1;
      else     freq_q <= freq_next;
    end
  end

  assign freq_o     = freq_q;
  assign chan_off_o = off_q;
endmodule

// File: rtl/swp_sweep_chk.sv
module swp_sweep_chk #(
  parameter int FREQ_W = 11,
  parameter int ADDR_W = 3,
  parameter int STEP_W = 3,
  parameter int PER_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              seq_tick,
  input logic [STEP_W-1:0] seq_step,
  input logic [FREQ_W-1:0] freq_o,
  input logic              chan_off_o,
  input logic [PER_W-1:0]  sweep_cnt,
  input logic [PER_W-1:0]  ctl_period,
  input logic              ctl_dec
);
  logic freq_wr, sweep_step;
  assign freq_wr    = wr_en && (wr_addr == ADDR_W'(3) || wr_addr == ADDR_W'(4));
  assign sweep_step = seq_tick && (seq_step == STEP_W'(2) || seq_step == STEP_W'(6));

  // R5
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_wr && !sweep_step) |=> $stable(freq_o));

  // R11
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !freq_wr) |=> $stable(freq_o));

  // R10
  off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_off_o && !(wr_en && wr_addr == ADDR_W'(4))) |=> chan_off_o);

  // R10
  off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_off_o) |-> $stable(freq_o));

  // R9
  dec_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_tick && !wr_en && ctl_dec) |=> (freq_o <= $past(freq_o)));

  // R8
  inc_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_tick && !wr_en && !ctl_dec) |=> (freq_o >= $past(freq_o)));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |=> (sweep_cnt == '0));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_cnt < ctl_period) || (sweep_cnt == '0));
endmodule

bind swp_sweep_unit swp_sweep_chk #(
  .FREQ_W(FREQ_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W), .PER_W(swp_pkg::PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .seq_tick(seq_tick), .seq_step(seq_step), .freq_o(freq_o),
  .chan_off_o(chan_off_o), .sweep_cnt(sweep_cnt),
  .ctl_period(ctl_period), .ctl_dec(ctl_dec)
);

// File: tb/swp_sweep_unit_test.sv
module swp_sweep_unit_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 50000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        seq_tick = 0;
  logic [2:0]  seq_step = 0;
  logic [10:0] freq_o;
  logic        chan_off_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_freq = 0, m_off = 0, m_cnt = 0;
  int m_regs [8];

  swp_sweep_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .seq_tick(seq_tick), .seq_step(seq_step), .freq_o(freq_o),
    .chan_off_o(chan_off_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_freq = 0; m_off = 0; m_cnt = 0;
      for (int i = 0; i < 8; i++) m_regs[i] = 0;
    end else if (wr_en) begin
      if (wr_addr < 5) m_regs[wr_addr] = wr_data;
      if (wr_addr == 0) m_cnt = 0;
      if (wr_addr == 3) m_freq = (m_freq & 'h700) | wr_data;
      if (wr_addr == 4) begin
        m_freq = (m_freq & 'hFF) | ((wr_data & 7) << 8);
        m_off = 0;
      end
    end else if (seq_tick && (seq_step == 2 || seq_step == 6)) begin
      int per, sh, d;
      per = (m_regs[0] >> 4) & 7;
      sh  = m_regs[0] & 7;
      if (per != 0 && sh != 0) begin
        m_cnt++;
        if (m_cnt >= per) begin
          m_cnt = 0;
          d = m_freq >> sh;
          if (m_regs[0] & 8) m_freq = (m_freq - d < 0) ? 0 : m_freq - d;
          else if (m_freq + d > 2047) m_off = 1;
          else m_freq = m_freq + d;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && !done) begin
      check("R7 freq", int'(freq_o), m_freq);
      check("R10 chan_off", int'(chan_off_o), m_off);
      check("R2 rd_data", int'(rd_data), m_regs[rd_addr]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic stp(int s);
    @(negedge clk);
    seq_tick = 1; seq_step = 3'(s);
    @(negedge clk);
    seq_tick = 0;
  endtask

  task automatic rd_expect(string req, int a, int exp);
    @(negedge clk);
    rd_addr = 3'(a);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 freq", int'(freq_o), 0);
    check("R1 chan_off", int'(chan_off_o), 0);
    for (int a = 0; a < 5; a++) rd_expect("R1 rd", a, 0);

    // R8 / R10: 1024 -> 1536 -> overflow
    wr(3, 'h00); wr(4, 'h04);
    check("R3 freq load", int'(freq_o), 1024);
    wr(0, 'h11);
    stp(2);
    check("R8 increase", int'(freq_o), 1536);
    stp(6);
    check("R10 overflow freq", int'(freq_o), 1536);
    check("R10 overflow flag", int'(chan_off_o), 1);
    rd_expect("R3 readback lo", 3, 'h00);
    rd_expect("R3 readback hi", 4, 'h04);
    wr(4, 'h04);
    check("R10 flag cleared", int'(chan_off_o), 0);
    check("R10 reload", int'(freq_o), 1024);

    // R5: non-eligible steps
    stp(0); stp(1); stp(3); stp(7);
    check("R5 off-step", int'(freq_o), 1024);

    // R7 / R9: period 2, decrease, shift 2
    wr(3, 100); wr(4, 0); wr(0, 'h2A);
    stp(2);
    check("R7 first step", int'(freq_o), 100);
    stp(6);
    check("R9 decrease", int'(freq_o), 75);

    // R6: shift 0, then period 0
    wr(0, 'h28); stp(2); stp(6); stp(2);
    check("R6 shift zero", int'(freq_o), 75);
    wr(0, 'h02); stp(2); stp(6);
    check("R6 period zero", int'(freq_o), 75);

    // R4: control write clears counter
    wr(0, 'h2A); stp(2); wr(0, 'h2A); stp(2);
    check("R4 cleared count", int'(freq_o), 75);
    stp(6);
    check("R4 update after", int'(freq_o), 57);

    // R11: write and tick in the same cycle
    wr(0, 'h11);
    @(negedge clk);
    wr_en = 1; wr_addr = 1; wr_data = 'h55; seq_tick = 1; seq_step = 2;
    @(negedge clk);
    wr_en = 0; seq_tick = 0;
    check("R11 dropped step", int'(freq_o), 57);
    rd_expect("R2 offset1", 1, 'h55);

    // R2: unused offsets
    wr(5, 'hAA); wr(7, 'hFF);
    rd_expect("R2 offset5", 5, 0);
    rd_expect("R2 offset7", 7, 0);
    rd_expect("R2 offset0", 0, 'h11);
    check("R2 freq untouched", int'(freq_o), 57);

    // R9: small value decrease stays non-negative
    wr(3, 3); wr(4, 0); wr(0, 'h19);
    stp(2);
    check("R9 small", int'(freq_o), 2);
    stp(6); stp(2);
    check("R9 floor", int'(freq_o), 1);

    // random phase compared every clock against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en    = ($urandom_range(0, 3) == 0);
      wr_addr  = 3'($urandom_range(0, 7));
      wr_data  = 8'($urandom_range(0, 255));
      seq_tick = ($urandom_range(0, 1) == 0);
      seq_step = 3'($urandom_range(0, 7));
      rd_addr  = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    wr_en = 0; seq_tick = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule